// File: doc/BRIEF.md
# 64-bit Interval Timer

This peripheral counts prescaled ticks in a 64-bit register and signals an event each time the count reaches a programmed 64-bit limit. Software reaches it through a plain word-wide register bus. The period is split into a low and a high word. A mode word selects continuous or single-shot operation, the tick source and a 4-bit prescaler. Software can read the running count as two words that are guaranteed to belong to the same instant.

The tick source is either every bus-clock cycle or a slower generic-clock pulse. That pulse arrives as a one-cycle enable in the bus clock domain and must occur at most once every three cycles. The chosen source is divided by P+1, so the ratio runs from 1 to 16. A sticky pending flag is set on every expiry. It is cleared by reading the status word, and it drives the interrupt line when the interrupt is enabled.

Software programs the block in a fixed order: software reset, mode, period high, period low, interrupt enable, start. A period of all ones turns the timer into a free-running counter. The run controller has two states. `ST_IDLE` moves to `ST_RUN` on a start request. `ST_RUN` stays in `ST_RUN` on continuous expiry, where the count wraps. `ST_RUN` returns to `ST_IDLE` on a software reset or on single-shot expiry. A software reset also forces `ST_IDLE` from either state.

Top module: `pit64_timer`

## Requirements
- R1: After rst_n the following are all zero: mode, period words, interrupt enable, pending flag and count. In addition, irq is low and the timer does not count until started.
- R2: Writing the control word (0x00) with bit 8 set stops the timer, zeroes the count and clears the pending flag. Bit 8 wins over bit 0 in the same write.
- R3: Writing the control word with bit 0 set (bit 8 clear) runs the timer from its present count and restarts the prescaler.
- R4: While running, the count rises by one per tick. With the bus-clock source, a tick occurs every P+1 cycles, where P is mode bits 11:8. The first expiry therefore falls (period+1)*(P+1) cycles after the start write.
- R5: The timer expires on a tick where the count equals the period {0x0C, 0x08}. In continuous mode (mode bit 0 = 1), the count then wraps to zero and the timer keeps running. Later expiries follow every (period+1)*(P+1) cycles.
- R6: In single-shot mode (mode bit 0 = 0), expiry stops the timer and the count holds at the period value.
- R7: With mode bit 3 = 1, only gen_clk_en pulses advance the prescaler, whatever the number of bus cycles.
- R8: Reading status (0x1C) returns the pending flag in bit 0 and clears it. If an expiry lands on the same cycle as that read, the read returns the old value and the flag stays set.
- R9: irq is the pending flag ANDed with bit 0 of the interrupt-enable word (0x10).
- R10: Reading 0x20 returns count bits [BUS_W-1:0] and copies the upper half into a shadow. Reading 0x24 returns that shadow, however many cycles separate the two reads.
- R11: rd_data is updated on the clock edge that samples rd_en and holds its value while rd_en is low. The mode word reads back only bits 0, 3 and 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | BUS_W | Registered read data |
| gen_clk_en | input | 1 | Generic-clock tick, one cycle wide |
| irq | output | 1 | Period interrupt |

## Verification
A write or read acts on the edge that samples its strobe. Read data and the interrupt level are therefore sampled at the falling edge that follows. Expiry is due exactly (period+1)*(P+1) rising edges after the start write. The bench counts falling edges from the start write until irq is high and compares that count with the formula. Same-cycle corner cases are placed by counting edges from the start write: the status read that coincides with an expiry, and the two snapshot reads that straddle a carry into the upper half.

// File: rtl/pit64_pkg.sv
package pit64_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Register byte offsets; software depends on these values.
    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_MODE   = 8'h04;
    localparam logic [7:0] OFF_PER_LO = 8'h08;
    localparam logic [7:0] OFF_PER_HI = 8'h0C;
    localparam logic [7:0] OFF_IEN    = 8'h10;
    localparam logic [7:0] OFF_STAT   = 8'h1C;
    localparam logic [7:0] OFF_VAL_LO = 8'h20;
    localparam logic [7:0] OFF_VAL_HI = 8'h24;

    // Field positions
    localparam int BIT_START = 0;
    localparam int BIT_SWRST = 8;
    localparam int BIT_CONT  = 0;
    localparam int BIT_GSEL  = 3;
    localparam int PRE_LSB   = 8;

endpackage

// File: rtl/pit64_prescaler.sv
module pit64_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_en,
    input  logic [PRE_W-1:0] ratio,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic             at_end;

    assign at_end = (div_q == ratio);
    assign tick   = src_en && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (src_en) begin
            div_q <= at_end ? '0 : div_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/pit64_core.sv
module pit64_core
    import pit64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             start_req,
    input  logic             tick,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire
);
    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (sw_rst) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else if (start_req) begin
            st_d = ST_RUN;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q == period) begin
                            expire = 1'b1;
                            if (cont) cnt_d = '0;
                            else      st_d  = ST_IDLE;
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign running = (st_q == ST_RUN);
endmodule

// File: rtl/pit64_regfile.sv
module pit64_regfile
    import pit64_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    parameter int PRE_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 rd_en,
    output logic [BUS_W-1:0]     rd_data,
    input  logic [2*BUS_W-1:0]   cnt,
    input  logic                 expire,
    output logic                 sw_rst,
    output logic                 start_req,
    output logic                 cont,
    output logic                 gsel,
    output logic [PRE_W-1:0]     ratio,
    output logic [2*BUS_W-1:0]   period,
    output logic                 pend,
    output logic                 irq_en,
    output logic                 irq
);
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic             ctrl_wr, stat_rd, lo_rd;
    logic             cont_q, gsel_q, ien_q, pend_q;
    logic [PRE_W-1:0] ratio_q;
    logic [BUS_W-1:0] per_lo_q, per_hi_q, shadow_q, rd_q, rd_next;

    assign ctrl_wr   = wr_en && hit(addr, OFF_CTRL);
    assign sw_rst    = ctrl_wr && wr_data[BIT_SWRST];
    assign start_req = ctrl_wr && wr_data[BIT_START] && !wr_data[BIT_SWRST];
    assign stat_rd   = rd_en && hit(addr, OFF_STAT);
    assign lo_rd     = rd_en && hit(addr, OFF_VAL_LO);

    // Configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q   <= 1'b0;
            gsel_q   <= 1'b0;
            ratio_q  <= '0;
            per_lo_q <= '0;
            per_hi_q <= '0;
            ien_q    <= 1'b0;
        end else if (wr_en) begin
            if (hit(addr, OFF_MODE)) begin
                cont_q  <= wr_data[BIT_CONT];
                gsel_q  <= wr_data[BIT_GSEL];
                ratio_q <= wr_data[PRE_LSB +: PRE_W];
            end
            if (hit(addr, OFF_PER_LO)) per_lo_q <= wr_data;
            if (hit(addr, OFF_PER_HI)) per_hi_q <= wr_data;
            if (hit(addr, OFF_IEN))    ien_q    <= wr_data[0];
        end
    end

    // Pending flag: a new expiry beats a clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (sw_rst)  pend_q <= 1'b0;
        else if (expire)  pend_q <= 1'b1;
        else if (stat_rd) pend_q <= 1'b0;
    end

    always_comb begin
        rd_next = '0;
        if (hit(addr, OFF_MODE)) begin
            rd_next[BIT_CONT]            = cont_q;
            rd_next[BIT_GSEL]            = gsel_q;
            rd_next[PRE_LSB +: PRE_W]    = ratio_q;
        end else if (hit(addr, OFF_PER_LO)) begin
            rd_next = per_lo_q;
        end else if (hit(addr, OFF_PER_HI)) begin
            rd_next = per_hi_q;
        end else if (hit(addr, OFF_IEN)) begin
            rd_next[0] = ien_q;
        end else if (hit(addr, OFF_STAT)) begin
            rd_next[0] = pend_q;
        end else if (hit(addr, OFF_VAL_LO)) begin
            rd_next = cnt[BUS_W-1:0];
        end else if (hit(addr, OFF_VAL_HI)) begin
            rd_next = shadow_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q     <= '0;
            shadow_q <= '0;
        end else begin
            if (rd_en) rd_q     <= rd_next;
            if (lo_rd) shadow_q <= cnt[2*BUS_W-1:BUS_W];
        end
    end

    assign rd_data = rd_q;
    assign cont    = cont_q;
    assign gsel    = gsel_q;
    assign ratio   = ratio_q;
    assign period  = {per_hi_q, per_lo_q};
    assign pend    = pend_q;
    assign irq_en  = ien_q;
    assign irq     = pend_q && ien_q;
endmodule

// File: rtl/pit64_timer.sv
module pit64_timer
    import pit64_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 8,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              gen_clk_en,
    output logic              irq
);
    localparam int CNT_W = 2 * BUS_W;

    logic             sw_rst, start_req, cont, gsel, tick, src_en;
    logic             running, expire, pend, irq_en;
    logic [PRE_W-1:0] ratio;
    logic [CNT_W-1:0] period, cnt;

    assign src_en = gsel ? gen_clk_en : 1'b1;

    pit64_regfile #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cnt(cnt), .expire(expire),
        .sw_rst(sw_rst), .start_req(start_req), .cont(cont), .gsel(gsel),
        .ratio(ratio), .period(period), .pend(pend), .irq_en(irq_en), .irq(irq)
    );

    pit64_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr(sw_rst || start_req),
        .src_en(src_en), .ratio(ratio), .tick(tick)
    );

    pit64_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start_req(start_req),
        .tick(tick), .cont(cont), .period(period), .cnt(cnt),
        .running(running), .expire(expire)
    );
endmodule

// File: rtl/pit64_timer_chk.sv
module pit64_timer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             start_req,
    input logic             tick,
    input logic             cont,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cnt,
    input logic             running,
    input logic             expire,
    input logic             pend,
    input logic             irq_en,
    input logic             irq
);
    p_swrst_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (cnt == '0) && !running);

    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> running);

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !sw_rst && !start_req && cnt != period)
        |=> cnt == $past(cnt) + CNT_W'(1));

    p_wrap_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cont) |=> (cnt == '0) && running);

    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont) |=> !running && cnt == $past(cnt));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sw_rst) |=> $stable(cnt));

    p_event_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);

    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

bind pit64_timer pit64_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .start_req(start_req),
    .tick(tick), .cont(cont), .period(period), .cnt(cnt), .running(running),
    .expire(expire), .pend(pend), .irq_en(irq_en), .irq(irq)
);

// File: tb/pit64_timer_tb_top.sv
module pit64_timer_tb_top;
    import pit64_pkg::*;

    localparam int BW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [BW-1:0] rd_data;
    logic          gen_clk_en = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pit64_timer #(.BUS_W(BW), .ADDR_W(AW), .PRE_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .gen_clk_en(gen_clk_en), .irq(irq)
    );

    // {prescaler, period low, expected cycles = (period+1)*(prescaler+1)}
    localparam logic [27:0] TBL [5] = '{
        {4'd0,  8'd3, 16'd4},
        {4'd1,  8'd4, 16'd10},
        {4'd3,  8'd2, 16'd12},
        {4'd15, 8'd1, 16'd32},
        {4'd0,  8'd0, 16'd1}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [BW-1:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [BW-1:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [BW-1:0] mode, input logic [BW-1:0] lo,
                         input logic [BW-1:0] hi, input logic [BW-1:0] ien);
        wr(OFF_CTRL, 16'h0100);
        wr(OFF_MODE, mode);
        wr(OFF_PER_HI, hi);
        wr(OFF_PER_LO, lo);
        wr(OFF_IEN, ien);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic gpulse;
        gen_clk_en = 1'b1;
        @(negedge clk);
        gen_clk_en = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [BW-1:0] d, keep;
        int n;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 irq after reset", irq, 0);
        rd(OFF_MODE, d);   check("R1 mode", d, 0);
        rd(OFF_PER_LO, d); check("R1 period lo", d, 0);
        rd(OFF_PER_HI, d); check("R1 period hi", d, 0);
        rd(OFF_IEN, d);    check("R1 ien", d, 0);
        rd(OFF_STAT, d);   check("R1 status", d, 0);
        idle(10);
        rd(OFF_VAL_LO, d); check("R1 count idle", d, 0);

        // R11 mode readback mask and hold
        wr(OFF_MODE, 16'hFFFF);
        rd(OFF_MODE, d);   check("R11 mode readback", d, 16'h0F09);
        keep = d;
        idle(5);
        check("R11 rd_data hold", rd_data, keep);

        // Table: R4 first expiry, R5 continuous repeat
        for (int i = 0; i < 5; i++) begin
            logic [3:0]  pres;
            logic [7:0]  per;
            logic [15:0] expn;
            pres = TBL[i][27:24];
            per  = TBL[i][23:16];
            expn = TBL[i][15:0];
            setup({4'h0, pres, 8'h01}, {8'h00, per}, 16'h0000, 16'h0001);
            wr(OFF_CTRL, 16'h0001);
            wait_irq(n);
            check($sformatf("R4 entry %0d first expiry", i), n, expn);
            if (expn > 1) begin
                rd(OFF_STAT, d);
                check($sformatf("R8 entry %0d status", i), d, 1);
                wait_irq(n);
                check($sformatf("R5 entry %0d next expiry", i), n, expn - 1);
            end
        end

        // R8 expiry on the same cycle as a status read
        setup(16'h0001, 16'd5, 16'h0000, 16'h0001);
        wr(OFF_CTRL, 16'h0001);
        idle(5);
        rd(OFF_STAT, d);
        check("R8 coincident read value", d, 0);
        check("R8 coincident flag kept", irq, 1);
        rd(OFF_STAT, d);
        check("R8 second read", d, 1);
        check("R8 cleared", irq, 0);

        // R6 single shot, then R3 restart from held count
        setup(16'h0000, 16'd3, 16'h0000, 16'h0001);
        wr(OFF_CTRL, 16'h0001);
        wait_irq(n);
        check("R6 one-shot expiry", n, 4);
        rd(OFF_VAL_LO, d); check("R6 count held", d, 3);
        idle(20);
        rd(OFF_VAL_LO, d); check("R6 count still held", d, 3);
        rd(OFF_STAT, d);   check("R6 status", d, 1);
        idle(20);
        check("R6 no re-expiry", irq, 0);
        wr(OFF_CTRL, 16'h0001);
        wait_irq(n);
        check("R3 restart from held count", n, 1);

        // R7 generic-clock source, prescaler 1, period 2 -> 6 pulses
        setup(16'h0109, 16'd2, 16'h0000, 16'h0001);
        wr(OFF_CTRL, 16'h0001);
        idle(50);
        check("R7 no pulses no expiry", irq, 0);
        for (int k = 0; k < 5; k++) gpulse();
        check("R7 five pulses", irq, 0);
        gen_clk_en = 1'b1;
        @(negedge clk);
        gen_clk_en = 1'b0;
        check("R7 sixth pulse", irq, 1);

        // R9 masked interrupt
        setup(16'h0001, 16'd1, 16'h0000, 16'h0000);
        wr(OFF_CTRL, 16'h0001);
        idle(10);
        check("R9 irq masked", irq, 0);
        rd(OFF_STAT, d);
        check("R9 pending while masked", d, 1);

        // R2 software reset
        setup(16'h0001, 16'd1, 16'h0000, 16'h0001);
        wr(OFF_CTRL, 16'h0001);
        idle(5);
        check("R2 pending before reset", irq, 1);
        wr(OFF_CTRL, 16'h0101);
        check("R2 pending cleared", irq, 0);
        rd(OFF_VAL_LO, d); check("R2 count zero", d, 0);
        idle(10);
        rd(OFF_VAL_LO, d); check("R2 stays stopped", d, 0);

        // R10 coherent snapshot across a carry into the upper half
        setup(16'h0001, 16'hFFFF, 16'hFFFF, 16'h0000);
        wr(OFF_CTRL, 16'h0001);
        idle(65500);
        rd(OFF_VAL_LO, d); check("R10 low read", d, 16'hFFDC);
        idle(100);
        rd(OFF_VAL_HI, d); check("R10 shadow before carry", d, 0);
        rd(OFF_VAL_LO, d); check("R10 low after carry", d, 16'h0042);
        rd(OFF_VAL_HI, d); check("R10 shadow after carry", d, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule